// File: doc/BRIEF.md
# Viterbi Traceback Decoder

This block turns the survivor decisions of a Viterbi decoder into decoded bits. An update unit writes one decision word per symbol step. Each word holds one bit per trellis state, and the words go into a circular memory. On request, the block starts from a start-state register, walks backwards through a chosen number of steps and returns one bit. That bit is the oldest bit on the surviving path.

The start-state register normally follows the minimum-cost state index reported by the update unit. Software can overwrite it with a known end state to force the walk along that path. A software write wins over an update-unit load in the same cycle. The walk depth is supplied with each start request and is clamped to the number of steps actually stored. While a walk is running, the block reports busy and refuses new decision words. A one-cycle ready pulse marks the output bit.

Top module: `viterbi_tbk`

## Requirements
- R1: After reset, `busy`, `ready`, `dec_bit` and `idx_q` are all 0, and the decision store counts zero stored steps.
- R2: When `min_idx_vld` is 1 and `sw_idx_we` is 0, `idx_q` takes `min_idx` on the next clock edge.
- R3: When `sw_idx_we` is 1, `idx_q` takes `sw_idx` on the next clock edge, even if `min_idx_vld` is 1 in the same cycle.
- R4: A `start` accepted while idle raises `busy` for exactly D cycles, where D is the effective depth. In the first cycle with `busy` low again, `ready` is 1 for exactly one cycle.
- R5: The walk begins at the newest stored step, from the state held in `idx_q` when `start` is accepted. At each step it reads the decision word at that step, using bit number equal to the current state value. The state of the step before is then the current state shifted right by one, with the read bit placed in the MSB.
- R6: `dec_bit` equals the LSB of the state reached at the oldest visited step, which is step number D-1 counting the newest as 0. It holds its value until the next `ready` pulse.
- R7: The effective depth D is `depth`, with a `depth` of 0 treated as 1, and limited to the number of stored steps.
- R8: The k-th accepted decision word (k counted from 0) is stored at address k modulo MEM_DEPTH. The stored-step count saturates at MEM_DEPTH, so after wrap-around the oldest words are overwritten.
- R9: A decision write (`dec_we`) made while `busy` is 1 is dropped. It is not stored and does not advance the store.
- R10: `start` is ignored while `busy` is 1, and it is ignored when no step is stored. In both cases no extra walk or `ready` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_we | input | 1 | Decision word write strobe from the update unit |
| dec_word | input | 2**STATE_W | One decision bit per state; bit i belongs to state i |
| min_idx_vld | input | 1 | Load strobe for the minimum-cost state index |
| min_idx | input | STATE_W | Minimum-cost state index from the update unit |
| sw_idx_we | input | 1 | Software write strobe for the start-state register |
| sw_idx | input | STATE_W | Forced start state from software |
| start | input | 1 | Request one traceback walk |
| depth | input | $clog2(MEM_DEPTH+1) | Walk depth for this request |
| busy | output | 1 | A walk is running |
| ready | output | 1 | One-cycle pulse, `dec_bit` is new |
| dec_bit | output | 1 | Decoded bit of the last walk |
| idx_q | output | STATE_W | Current start-state register |

## Verification
Two pairs of actions can land in the same clock cycle. The first pair is a software force and an update-unit load of the start-state register. The bench drives both strobes on one edge with different values and expects the software value in `idx_q` on the next cycle. The second pair is a new decision word or a second `start` arriving while a walk is in flight. The bench injects both partway through a long walk. It then judges them by the walk's length, by the single `ready` pulse, and by a follow-up probe walk of depth STATE_W+1 from state 0. That probe returns bit 0 of the newest stored word, so it shows whether the dropped word reached the store.

// File: rtl/tbk_pkg.sv
package tbk_pkg;
    localparam int TBK_STATE_W   = 6;     // constraint length 7
    localparam int TBK_MEM_DEPTH = 1024;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_mode_e;

    typedef struct packed {
        logic [TBK_STATE_W-1:0] state;
        logic [$clog2(TBK_MEM_DEPTH)-1:0] addr;
        logic [$clog2(TBK_MEM_DEPTH+1)-1:0] left;
    } walk_ctx_t;
endpackage

// File: rtl/tbk_idx_reg.sv
module tbk_idx_reg #(
    parameter int STATE_W = tbk_pkg::TBK_STATE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               min_vld,
    input  logic [STATE_W-1:0] min_idx,
    input  logic               sw_we,
    input  logic [STATE_W-1:0] sw_idx,
    output logic [STATE_W-1:0] idx_q
);
    // software force takes priority over the update-unit load
    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (sw_we)
            idx_q <= sw_idx;
        else if (min_vld)
            idx_q <= min_idx;
    end
endmodule

// File: rtl/tbk_dec_mem.sv
module tbk_dec_mem #(
    parameter int STATE_W   = tbk_pkg::TBK_STATE_W,
    parameter int MEM_DEPTH = tbk_pkg::TBK_MEM_DEPTH
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic [(1<<STATE_W)-1:0]              wr_word,
    input  logic [$clog2(MEM_DEPTH)-1:0]         rd_addr,
    output logic [(1<<STATE_W)-1:0]              rd_word,
    output logic [$clog2(MEM_DEPTH)-1:0]         newest,
    output logic [$clog2(MEM_DEPTH+1)-1:0]       stored
);
    localparam int NSTATE = 1 << STATE_W;
    localparam int ADDR_W = $clog2(MEM_DEPTH);
    localparam int CNT_W  = $clog2(MEM_DEPTH + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(MEM_DEPTH - 1);
    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(MEM_DEPTH);

    logic [NSTATE-1:0] mem [MEM_DEPTH];
    logic [ADDR_W-1:0] wr_ptr;

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            stored <= '0;
        end else if (wr_en) begin
            wr_ptr <= (wr_ptr == LAST_ADDR) ? '0 : wr_ptr + 1'b1;
            if (stored != FULL_CNT)
                stored <= stored + 1'b1;
        end
    end

    assign newest  = (wr_ptr == '0) ? LAST_ADDR : wr_ptr - 1'b1;
    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/tbk_walk.sv
module tbk_walk #(
    parameter int STATE_W   = tbk_pkg::TBK_STATE_W,
    parameter int MEM_DEPTH = tbk_pkg::TBK_MEM_DEPTH
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 start,
    input  logic [$clog2(MEM_DEPTH+1)-1:0]       depth,
    input  logic [STATE_W-1:0]                   idx_q,
    input  logic [$clog2(MEM_DEPTH+1)-1:0]       stored,
    input  logic [$clog2(MEM_DEPTH)-1:0]         newest,
    input  logic [(1<<STATE_W)-1:0]              rd_word,
    output logic [$clog2(MEM_DEPTH)-1:0]         rd_addr,
    output logic                                 busy,
    output logic                                 ready,
    output logic                                 dec_bit
);
    import tbk_pkg::*;
    localparam int ADDR_W = $clog2(MEM_DEPTH);
    localparam int CNT_W  = $clog2(MEM_DEPTH + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(MEM_DEPTH - 1);

    walk_mode_e mode;
    logic [STATE_W-1:0] cur_st;
    logic [ADDR_W-1:0]  cur_addr;
    logic [CNT_W-1:0]   left;
    logic [CNT_W-1:0]   req_depth;
    logic [CNT_W-1:0]   eff_depth;
    logic               step_bit;

    always_comb begin
        req_depth = (depth == '0) ? CNT_W'(1) : depth;
        eff_depth = (req_depth > stored) ? stored : req_depth;
    end

    assign step_bit = rd_word[cur_st];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= WALK_IDLE;
            cur_st   <= '0;
            cur_addr <= '0;
            left     <= '0;
            ready    <= 1'b0;
            dec_bit  <= 1'b0;
        end else begin
            ready <= 1'b0;
            unique case (mode)
                WALK_IDLE: begin
                    if (start && stored != '0) begin
                        cur_st   <= idx_q;
                        cur_addr <= newest;
                        left     <= eff_depth;
                        mode     <= WALK_RUN;
                    end
                end
                WALK_RUN: begin
                    cur_st   <= {step_bit, cur_st[STATE_W-1:1]};
                    cur_addr <= (cur_addr == '0) ? LAST_ADDR : cur_addr - 1'b1;
                    left     <= left - 1'b1;
                    if (left == CNT_W'(1)) begin
                        mode    <= WALK_IDLE;
                        ready   <= 1'b1;
                        dec_bit <= cur_st[0];
                    end
                end
                default: mode <= WALK_IDLE;
            endcase
        end
    end

    assign busy    = (mode == WALK_RUN);
    assign rd_addr = cur_addr;
endmodule

// File: rtl/viterbi_tbk.sv
module viterbi_tbk #(
    parameter int STATE_W   = tbk_pkg::TBK_STATE_W,
    parameter int MEM_DEPTH = tbk_pkg::TBK_MEM_DEPTH,
    localparam int NSTATE   = 1 << STATE_W,
    localparam int ADDR_W   = $clog2(MEM_DEPTH),
    localparam int CNT_W    = $clog2(MEM_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dec_we,
    input  logic [NSTATE-1:0]  dec_word,
    input  logic               min_idx_vld,
    input  logic [STATE_W-1:0] min_idx,
    input  logic               sw_idx_we,
    input  logic [STATE_W-1:0] sw_idx,
    input  logic               start,
    input  logic [CNT_W-1:0]   depth,
    output logic               busy,
    output logic               ready,
    output logic               dec_bit,
    output logic [STATE_W-1:0] idx_q
);
    logic [NSTATE-1:0] rd_word;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] newest;
    logic [CNT_W-1:0]  stored;
    logic              wr_ok;

    // decision store is locked while a walk runs
    assign wr_ok = dec_we && !busy;

    tbk_idx_reg #(.STATE_W(STATE_W)) u_idx (
        .clk(clk), .rst(rst),
        .min_vld(min_idx_vld), .min_idx(min_idx),
        .sw_we(sw_idx_we), .sw_idx(sw_idx),
        .idx_q(idx_q)
    );

    tbk_dec_mem #(.STATE_W(STATE_W), .MEM_DEPTH(MEM_DEPTH)) u_mem (
        .clk(clk), .rst(rst),
        .wr_en(wr_ok), .wr_word(dec_word),
        .rd_addr(rd_addr), .rd_word(rd_word),
        .newest(newest), .stored(stored)
    );

    tbk_walk #(.STATE_W(STATE_W), .MEM_DEPTH(MEM_DEPTH)) u_walk (
        .clk(clk), .rst(rst),
        .start(start), .depth(depth), .idx_q(idx_q),
        .stored(stored), .newest(newest), .rd_word(rd_word),
        .rd_addr(rd_addr), .busy(busy), .ready(ready), .dec_bit(dec_bit)
    );
endmodule

// File: rtl/tbk_chk.sv
module tbk_chk #(
    parameter int STATE_W = tbk_pkg::TBK_STATE_W
) (
    input logic               clk,
    input logic               rst,
    input logic               min_idx_vld,
    input logic [STATE_W-1:0] min_idx,
    input logic               sw_idx_we,
    input logic [STATE_W-1:0] sw_idx,
    input logic               busy,
    input logic               ready,
    input logic               dec_bit,
    input logic [STATE_W-1:0] idx_q
);
    // R2
    min_idx_load_chk: assert property (@(posedge clk) disable iff (rst)
        (min_idx_vld && !sw_idx_we) |=> (idx_q == $past(min_idx)));

    // R3
    sw_idx_wins_chk: assert property (@(posedge clk) disable iff (rst)
        sw_idx_we |=> (idx_q == $past(sw_idx)));

    // R4
    ready_single_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    // R4
    ready_after_walk_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!busy && $past(busy)));

    // R4
    walk_end_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ready);

    // R6
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |-> $stable(dec_bit));
endmodule

bind viterbi_tbk tbk_chk #(.STATE_W(STATE_W)) u_chk (
    .clk(clk), .rst(rst),
    .min_idx_vld(min_idx_vld), .min_idx(min_idx),
    .sw_idx_we(sw_idx_we), .sw_idx(sw_idx),
    .busy(busy), .ready(ready), .dec_bit(dec_bit), .idx_q(idx_q)
);

// File: tb/viterbi_tbk_test.sv
`timescale 1ns/1ps
module viterbi_tbk_test;
    localparam int W      = tbk_pkg::TBK_STATE_W;
    localparam int DEPTH  = tbk_pkg::TBK_MEM_DEPTH;
    localparam int NST    = 1 << W;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic             dec_we;
    logic [NST-1:0]   dec_word;
    logic             min_idx_vld;
    logic [W-1:0]     min_idx;
    logic             sw_idx_we;
    logic [W-1:0]     sw_idx;
    logic             start;
    logic [CNT_W-1:0] depth;
    logic             busy, ready, dec_bit;
    logic [W-1:0]     idx_q;

    viterbi_tbk uut (
        .clk(clk), .rst(rst), .dec_we(dec_we), .dec_word(dec_word),
        .min_idx_vld(min_idx_vld), .min_idx(min_idx),
        .sw_idx_we(sw_idx_we), .sw_idx(sw_idx),
        .start(start), .depth(depth),
        .busy(busy), .ready(ready), .dec_bit(dec_bit), .idx_q(idx_q)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model of the decision store
    logic [NST-1:0] bm [DEPTH];
    int wr_total = 0;
    logic [W-1:0] path_st = '0;
    logic ubits [64];

    task automatic check(input string req, input longint got, input longint exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    function automatic int stored_cnt();
        return (wr_total > DEPTH) ? DEPTH : wr_total;
    endfunction

    function automatic int eff_of(input int d);
        int r = (d == 0) ? 1 : d;
        return (r > stored_cnt()) ? stored_cnt() : r;
    endfunction

    function automatic logic ref_trace(input logic [W-1:0] s0, input int d);
        logic [W-1:0] s = s0;
        int eff = eff_of(d);
        int a = (wr_total - 1) % DEPTH;
        for (int i = 0; i < eff; i++) begin
            if (i == eff - 1) return s[0];
            s = {bm[a][s], s[W-1:1]};
            a = (a == 0) ? DEPTH - 1 : a - 1;
        end
        return 1'b0;
    endfunction

    task automatic push(input logic [NST-1:0] w);
        @(negedge clk);
        dec_we = 1'b1; dec_word = w;
        @(negedge clk);
        dec_we = 1'b0;
        bm[wr_total % DEPTH] = w;
        wr_total++;
    endtask

    function automatic logic [NST-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    // one walk; inj >= 1 injects start and a decision write at that busy cycle
    task automatic walk(input int d, input int inj, input logic [NST-1:0] injw,
                        output logic b, output int nbusy, output int nready);
        @(negedge clk);
        start = 1'b1; depth = CNT_W'(d);
        @(negedge clk);
        start = 1'b0;
        nbusy = 0; nready = 0; b = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            if (ready) begin
                nready++; b = dec_bit;
            end
            if (busy) nbusy++;
            if (!busy && nready != 0) break;
            if (busy && nbusy == inj) begin
                start = 1'b1; dec_we = 1'b1; dec_word = injw;
            end else begin
                start = 1'b0; dec_we = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; dec_we = 1'b0;
        // watch for a stray second ready
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (ready) nready++;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; dec_we = 0; dec_word = '0; min_idx_vld = 0; min_idx = '0;
        sw_idx_we = 0; sw_idx = '0; start = 0; depth = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 ready", ready, 0);
        check("R1 dec_bit", dec_bit, 0);
        check("R1 idx_q", idx_q, 0);
    endtask

    task automatic t_empty_start();
        int seen = 0;
        @(negedge clk);
        start = 1'b1; depth = CNT_W'(5);
        @(negedge clk);
        start = 1'b0;
        repeat (8) begin
            if (busy || ready) seen++;
            @(negedge clk);
        end
        check("R10 start with nothing stored", seen, 0);
    endtask

    task automatic t_index();
        @(negedge clk);
        min_idx_vld = 1; min_idx = 6'd21;
        @(negedge clk);
        min_idx_vld = 0;
        check("R2 min load", idx_q, 21);
        min_idx_vld = 1; min_idx = 6'd9; sw_idx_we = 1; sw_idx = 6'd50;
        @(negedge clk);
        min_idx_vld = 0; sw_idx_we = 0;
        check("R3 force beats load", idx_q, 50);
    endtask

    task automatic t_path();
        logic [W-1:0] prev;
        logic b; int nb, nr;
        int depths [4] = '{1, 6, 20, 40};
        for (int t = 0; t < 40; t++) begin
            logic [NST-1:0] w = rnd_word();
            prev = path_st;
            ubits[t] = $urandom_range(0, 1);
            path_st = {prev[W-2:0], ubits[t]};
            w[path_st] = prev[W-1];
            push(w);
        end
        @(negedge clk);
        min_idx_vld = 1; min_idx = path_st;
        @(negedge clk);
        min_idx_vld = 0;
        foreach (depths[i]) begin
            walk(depths[i], 0, '0, b, nb, nr);
            check("R4 busy length", nb, depths[i]);
            check("R4 one ready", nr, 1);
            check("R5 R6 path bit", b, ubits[40 - depths[i]]);
        end
    endtask

    task automatic t_forced();
        logic b; int nb, nr;
        for (int i = 0; i < 4; i++) begin
            logic [W-1:0] s = W'($urandom);
            int d = 7 + i * 9;
            @(negedge clk);
            sw_idx_we = 1; sw_idx = s;
            @(negedge clk);
            sw_idx_we = 0;
            walk(d, 0, '0, b, nb, nr);
            check("R3 R5 forced start bit", b, ref_trace(s, d));
        end
    endtask

    task automatic t_clamp();
        logic b; int nb, nr;
        walk(1000, 0, '0, b, nb, nr);
        check("R7 depth clamped to stored", nb, stored_cnt());
        check("R7 clamped bit", b, ref_trace(idx_q, 1000));
        walk(0, 0, '0, b, nb, nr);
        check("R7 depth zero acts as one", nb, 1);
        check("R7 depth zero bit", b, idx_q[0]);
    endtask

    task automatic t_busy_block();
        logic b; int nb, nr;
        logic [NST-1:0] w;
        @(negedge clk);
        sw_idx_we = 1; sw_idx = '0;
        @(negedge clk);
        sw_idx_we = 0;
        w = bm[(wr_total - 1) % DEPTH];
        w[0] = ~w[0];
        walk(30, 5, w, b, nb, nr);
        check("R10 start in busy no restart", nb, 30);
        check("R10 start in busy one ready", nr, 1);
        // probe: depth W+1 from state 0 yields bit 0 of newest word
        walk(W + 1, 0, '0, b, nb, nr);
        check("R9 write in busy dropped", b, bm[(wr_total - 1) % DEPTH][0]);
    endtask

    task automatic t_wrap();
        logic b; int nb, nr;
        logic [W-1:0] s;
        for (int i = 0; i < 1100; i++) push(rnd_word());
        s = W'($urandom);
        @(negedge clk);
        sw_idx_we = 1; sw_idx = s;
        @(negedge clk);
        sw_idx_we = 0;
        walk(2000, 0, '0, b, nb, nr);
        check("R8 saturated count", nb, DEPTH);
        check("R8 wrapped trace bit", b, ref_trace(s, 2000));
        @(negedge clk);
        sw_idx_we = 1; sw_idx = '0;
        @(negedge clk);
        sw_idx_we = 0;
        walk(W + 1, 0, '0, b, nb, nr);
        check("R8 newest after wrap", b, bm[(wr_total - 1) % DEPTH][0]);
    endtask

    initial begin
        t_reset();
        t_empty_start();
        t_index();
        t_path();
        t_forced();
        t_clamp();
        t_busy_block();
        t_wrap();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired got=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule